// File: doc/BRIEF.md
# Two-Slot Interchip Voice Serial Port

This block moves 8-bit voice samples across a four-wire interchip link that carries two B time slots per frame. The link wires are a frame sync pulse, a bit clock, a serial transmit line and a serial receive line. A channel-select input picks one of the two slots. In that slot the block shifts out a parallel transmit sample and shifts in a receive sample. Outside it, the transmit line is released so that other devices on the shared wire can drive it.

The block runs on a fast system clock and oversamples the link bit clock. Rising bit-clock edges launch transmit bits and falling edges capture receive bits. The link mode is strapped: the port goes active only after a static mode pin has been seen high at two frame syncs in a row. It falls back to idle at the first frame boundary that finds the pin low. The transmit pad's high-impedance state is the drive-enable output held low.

Top module: `idl_port`

## Requirements
- R1: After reset `link_active`, `lk_txd_oe`, `lk_txd` and `rx_strobe` are all 0, and the frame position counter rests beyond both slots.
- R2: A frame boundary is a falling bit-clock edge that finds `lk_sync` high. `link_active` rises at a boundary only if `mode_strap` is high there and was also high at the boundary just before. The first boundary after reset never activates the port.
- R3: A boundary that finds `mode_strap` low clears `link_active`. A strap that drops in the middle of a frame has no effect until that next boundary, and the rest of the current frame is still transferred.
- R4: Bit periods are numbered by rising bit-clock edges after the boundary, the first rising edge starting period 1. With `chan_sel`=0 (slot B1), the transmit bits are driven in periods 1 to 8, most significant bit first.
- R5: With `chan_sel`=1 (slot B2), the transmit bits are driven in periods 11 to 18, ten periods after the B1 slot, most significant bit first.
- R6: `lk_txd_oe` is 1 only during the 8 periods of the selected slot of an active frame. At all other times, including the other channel's slot and every period while inactive, it is 0 (line released) and `lk_txd` is 0.
- R7: `tx_sample` is captured at the boundary. Changes to it later in the frame do not alter the bits sent.
- R8: Receive bits are sampled on the falling edge that ends each period of the selected slot, most significant bit first. Data placed in the other slot is ignored.
- R9: In an active frame, `rx_strobe` pulses for exactly one system clock after the eighth receive bit, and `rx_sample` then holds the byte. An inactive frame produces no strobe.
- R10: `chan_sel` is captured at the boundary and selects the same slot for transmit and for receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_strap | input | 1 | Static link-mode strap |
| chan_sel | input | 1 | Slot select: 0 = B1, 1 = B2 |
| tx_sample | input | DW | Parallel sample to transmit |
| lk_bclk | input | 1 | Link bit clock |
| lk_sync | input | 1 | Link frame sync, one bit period wide |
| lk_rxd | input | 1 | Link serial receive data |
| lk_txd | output | 1 | Link serial transmit data |
| lk_txd_oe | output | 1 | Transmit drive enable (0 = high impedance) |
| rx_sample | output | DW | Last received sample |
| rx_strobe | output | 1 | One-cycle pulse when `rx_sample` is updated |
| link_active | output | 1 | Link mode detected |

## Verification
The main patterns are byte pairs such as A5/3C, 5A/C3, FF/00 and 00/FF, sent in both slots. The alternating patterns show whether the bit order is reversed or off by one period, and the all-ones and all-zeros bytes separate a driven line from a released one. During each active frame the receive line carries the inverted byte in the unselected slot, and the transmit input is inverted after the boundary. A port that listens in the wrong slot, or that samples its transmit word late, therefore gives visibly different data. The strap sequences include a single high frame after reset, a low frame, and a drop in the middle of a frame, which tell apart the two-sync entry rule, the exit at the boundary, and the case of a mode change taking effect too early.

// File: rtl/idl_pkg.sv
package idl_pkg;
  // First bit period of a slot: B1 at period 1, B2 shifted by the slot gap.
  function automatic int slot_first(input logic chan, input int gap);
    return chan ? (1 + gap) : 1;
  endfunction

  // True when a bit period lies within a slot of the given width.
  function automatic logic in_slot(input int pos, input int first, input int bits);
    return (pos >= first) && (pos < first + bits);
  endfunction
endpackage

// File: rtl/idl_edge.sv
module idl_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  output logic rise,
  output logic fall
);
  logic bclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= bclk;
  end

  assign rise = bclk & ~bclk_q;
  assign fall = ~bclk & bclk_q;
endmodule

// File: rtl/idl_frame.sv
module idl_frame #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          fall,
  input  logic          sync,
  input  logic          mode_strap,
  input  logic          chan_sel,
  output logic          frame_evt,
  output logic [CW-1:0] cnt,
  output logic          chan_q,
  output logic          active
);
  localparam logic [CW-1:0] CMAX = '1;

  logic strap_seen;

  assign frame_evt = fall & sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= CMAX;
      chan_q     <= 1'b0;
      active     <= 1'b0;
      strap_seen <= 1'b0;
    end else begin
      if (frame_evt) begin
        cnt        <= '0;
        chan_q     <= chan_sel;
        active     <= mode_strap & strap_seen;
        strap_seen <= mode_strap;
      end else if (rise && cnt != CMAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/idl_tx.sv
module idl_tx
  import idl_pkg::*;
#(
  parameter int DW  = 8,
  parameter int GAP = 10,
  parameter int CW  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_evt,
  input  logic          rise,
  input  logic          active,
  input  logic          chan_q,
  input  logic [CW-1:0] cnt,
  input  logic [DW-1:0] tx_sample,
  output logic          txd,
  output logic          oe
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [DW-1:0] sreg;
  logic [CW-1:0] ncnt;
  logic          hit;

  assign ncnt = (cnt == CMAX) ? cnt : cnt + 1'b1;
  assign hit  = in_slot(int'(ncnt), slot_first(chan_q, GAP), DW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      txd  <= 1'b0;
      oe   <= 1'b0;
    end else begin
      if (frame_evt) sreg <= tx_sample;
      if (!active) begin
        txd <= 1'b0;
        oe  <= 1'b0;
      end else if (rise) begin
        if (hit) begin
          txd  <= sreg[DW-1];
          oe   <= 1'b1;
          sreg <= {sreg[DW-2:0], 1'b0};
        end else begin
          txd <= 1'b0;
          oe  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/idl_rx.sv
module idl_rx
  import idl_pkg::*;
#(
  parameter int DW  = 8,
  parameter int GAP = 10,
  parameter int CW  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall,
  input  logic          active,
  input  logic          chan_q,
  input  logic [CW-1:0] cnt,
  input  logic          rxd,
  output logic [DW-1:0] rx_sample,
  output logic          rx_strobe
);
  logic [DW-1:0] sreg;
  logic          take;
  logic          last;
  int            first;

  assign first = slot_first(chan_q, GAP);
  assign take  = fall & active & in_slot(int'(cnt), first, DW);
  assign last  = (int'(cnt) == first + DW - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg      <= '0;
      rx_sample <= '0;
      rx_strobe <= 1'b0;
    end else begin
      rx_strobe <= 1'b0;
      if (take) begin
        sreg <= {sreg[DW-2:0], rxd};
        if (last) begin
          rx_sample <= {sreg[DW-2:0], rxd};
          rx_strobe <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/idl_port.sv
module idl_port #(
  parameter int DW  = 8,
  parameter int GAP = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_strap,
  input  logic          chan_sel,
  input  logic [DW-1:0] tx_sample,
  input  logic          lk_bclk,
  input  logic          lk_sync,
  input  logic          lk_rxd,
  output logic          lk_txd,
  output logic          lk_txd_oe,
  output logic [DW-1:0] rx_sample,
  output logic          rx_strobe,
  output logic          link_active
);
  localparam int LAST = 1 + GAP + DW;
  localparam int CW   = $clog2(LAST + 2);

  logic          rise;
  logic          fall;
  logic          frame_evt;
  logic [CW-1:0] cnt;
  logic          chan_q;

  idl_edge u_edge (
    .clk(clk), .rst_n(rst_n), .bclk(lk_bclk), .rise(rise), .fall(fall)
  );

  idl_frame #(.CW(CW)) u_frame (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .sync(lk_sync),
    .mode_strap(mode_strap), .chan_sel(chan_sel), .frame_evt(frame_evt),
    .cnt(cnt), .chan_q(chan_q), .active(link_active)
  );

  idl_tx #(.DW(DW), .GAP(GAP), .CW(CW)) u_tx (
    .clk(clk), .rst_n(rst_n), .frame_evt(frame_evt), .rise(rise),
    .active(link_active), .chan_q(chan_q), .cnt(cnt), .tx_sample(tx_sample),
    .txd(lk_txd), .oe(lk_txd_oe)
  );

  idl_rx #(.DW(DW), .GAP(GAP), .CW(CW)) u_rx (
    .clk(clk), .rst_n(rst_n), .fall(fall), .active(link_active),
    .chan_q(chan_q), .cnt(cnt), .rxd(lk_rxd), .rx_sample(rx_sample),
    .rx_strobe(rx_strobe)
  );
endmodule

// File: rtl/idl_port_chk.sv
module idl_port_chk
  import idl_pkg::*;
#(
  parameter int DW  = 8,
  parameter int GAP = 10,
  parameter int CW  = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_evt,
  input logic [CW-1:0] cnt,
  input logic          chan_q,
  input logic          active,
  input logic          oe,
  input logic          txd,
  input logic          strobe
);
  // R6: the drive enable is only ever seen inside the selected slot
  a_r6_oe_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> in_slot(int'(cnt), slot_first(chan_q, GAP), DW));

  // R6: a released line carries no data
  a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !txd);

  // R6: no drive one cycle after the port is inactive
  a_r6_off_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !oe);

  // R2/R3: mode only changes at a frame boundary
  a_r3_mode_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_evt |=> $stable(active));

  // R4: the position counter restarts at each boundary
  a_r4_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |=> (cnt == '0));

  // R9: the receive strobe is a single-cycle pulse
  a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
endmodule

bind idl_port idl_port_chk #(.DW(DW), .GAP(GAP), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_evt(frame_evt), .cnt(cnt),
  .chan_q(chan_q), .active(link_active), .oe(lk_txd_oe), .txd(lk_txd),
  .strobe(rx_strobe)
);

// File: tb/test_idl_port.sv
module test_idl_port;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int GAP        = 10;
  localparam int FRAME_LEN  = 32;
  localparam int HALF_BIT   = 4;
  localparam int NVEC       = 8;
  localparam int WATCHDOG   = 100000;

  // vector: {mode, chan, tx byte, rx byte}
  localparam logic [17:0] VECS [NVEC] = '{
    {1'b1, 1'b0, 8'hA5, 8'h3C},
    {1'b1, 1'b0, 8'hA5, 8'h3C},
    {1'b1, 1'b1, 8'h5A, 8'hC3},
    {1'b1, 1'b0, 8'hFF, 8'h00},
    {1'b1, 1'b1, 8'h00, 8'hFF},
    {1'b0, 1'b0, 8'h81, 8'h7E},
    {1'b1, 1'b1, 8'h96, 8'h69},
    {1'b1, 1'b1, 8'h96, 8'h69}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_strap = 1'b0;
  logic          chan_sel = 1'b0;
  logic [DW-1:0] tx_sample = '0;
  logic          lk_bclk = 1'b0;
  logic          lk_sync = 1'b0;
  logic          lk_rxd = 1'b0;
  logic          lk_txd;
  logic          lk_txd_oe;
  logic [DW-1:0] rx_sample;
  logic          rx_strobe;
  logic          link_active;

  int n_chk = 0;
  int n_fail = 0;
  int strobes = 0;
  int streak = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idl_port #(.DW(DW), .GAP(GAP)) i_idl_port (
    .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .chan_sel(chan_sel),
    .tx_sample(tx_sample), .lk_bclk(lk_bclk), .lk_sync(lk_sync),
    .lk_rxd(lk_rxd), .lk_txd(lk_txd), .lk_txd_oe(lk_txd_oe),
    .rx_sample(rx_sample), .rx_strobe(rx_strobe), .link_active(link_active)
  );

  always @(negedge clk) if (rx_strobe) strobes++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One frame; drop_p >= 0 lowers the strap in that bit period.
  task automatic run_frame(input logic mode, input logic chan,
                           input logic [DW-1:0] tx, input logic [DW-1:0] rx,
                           input int drop_p);
    bit exp_act;
    int first, other;
    logic exp_oe, exp_txd;
    exp_act = mode && (streak >= 1);
    streak  = mode ? streak + 1 : 0;
    first   = chan ? 1 + GAP : 1;
    other   = chan ? 1 : 1 + GAP;
    mode_strap = mode;
    chan_sel   = chan;
    tx_sample  = tx;
    strobes    = 0;
    for (int p = 0; p < FRAME_LEN; p++) begin
      lk_bclk = 1'b1;
      lk_sync = (p == 0);
      if (p >= first && p < first + DW)      lk_rxd = rx[DW-1-(p-first)];
      else if (p >= other && p < other + DW) lk_rxd = ~rx[DW-1-(p-other)];
      else                                   lk_rxd = p[0];
      if (p == 2) tx_sample = ~tx;                 // R7: late change ignored
      if (p == drop_p) begin
        mode_strap = 1'b0;
        streak = 0;
      end
      wait_clk(2);
      exp_oe  = exp_act && (p >= first) && (p < first + DW);
      exp_txd = exp_oe ? tx[DW-1-(p-first)] : 1'b0;
      if (chan) check(lk_txd_oe == exp_oe, "R5/R6 oe", lk_txd_oe, exp_oe);
      else      check(lk_txd_oe == exp_oe, "R4/R6 oe", lk_txd_oe, exp_oe);
      check(lk_txd == exp_txd, "R4/R5/R7 txd", lk_txd, exp_txd);
      wait_clk(HALF_BIT - 2);
      lk_bclk = 1'b0;
      wait_clk(HALF_BIT);
    end
    check(link_active == exp_act, "R2/R3 link_active", link_active, exp_act);
    check(strobes == (exp_act ? 1 : 0), "R9 strobe count", strobes, exp_act ? 1 : 0);
    if (exp_act) check(rx_sample == rx, "R8/R10 rx_sample", rx_sample, rx);
  endtask

  initial begin
    wait_clk(3);
    // R1: reset state
    check(link_active == 1'b0, "R1 link_active", link_active, 0);
    check(lk_txd_oe == 1'b0, "R1 oe", lk_txd_oe, 0);
    check(lk_txd == 1'b0, "R1 txd", lk_txd, 0);
    check(rx_strobe == 1'b0, "R1 strobe", rx_strobe, 0);
    rst_n = 1'b1;
    wait_clk(3);
    for (int v = 0; v < NVEC; v++)
      run_frame(VECS[v][17], VECS[v][16], VECS[v][15:8], VECS[v][7:0], -1);
    // R3: strap drops mid-frame; the frame still completes
    run_frame(1'b1, 1'b0, 8'hC6, 8'h39, 5);
    // R3: next frame finds the strap low and goes idle
    run_frame(1'b0, 1'b0, 8'hC6, 8'h39, -1);
    // R2: a single high frame after a low one does not activate
    run_frame(1'b1, 1'b1, 8'h3F, 8'hE1, -1);
    run_frame(1'b1, 1'b1, 8'h3F, 8'hE1, -1);
    // R1: asynchronous reset returns the port to idle
    rst_n = 1'b0;
    wait_clk(2);
    check(link_active == 1'b0, "R1 link_active after reset", link_active, 0);
    check(lk_txd_oe == 1'b0, "R1 oe after reset", lk_txd_oe, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_clk(WATCHDOG);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule